// File: doc/BRIEF.md
# Synchronous Serial Byte Transmitter with Automatic Clock Wait

This block sends bytes over a clocked serial link. Software-side logic writes a byte into a one-entry holding buffer; the engine moves it into a shift register and drives it out most significant bit first, one bit per serial clock. The data line changes on the falling edge of the serial clock, so a receiver samples on the rising edge. Between transfers both the serial clock and the data line rest high.

The block runs in one of two clock modes. In the first it makes its own serial clock by dividing the system clock. When the buffer runs dry at the end of a byte, it holds that clock high and waits for the next write. In the second it follows a serial clock from outside, brought in through a synchronizer. There it cannot stall the link, so a byte slot with nothing to send raises a sticky error flag and an interrupt.

Transmission stops in one of two ways. A graceful stop clears the enable bit and lets the current byte finish. An abort writes the inhibit bit, which stops at once and returns every flag and the buffer to their reset values.

Top module: `sync_ser_tx`

## Requirements
- R1: Each byte is sent as 8 bits, most significant bit first. The data output changes only at a falling edge of the serial clock and is stable at the following rising edge.
- R2: A write with `wr_sel_i`=1 stores `wr_data_i` as the next byte, and `buf_empty_o` reads 0 on the next cycle. When a byte moves from the buffer to the shift register, `buf_empty_o` returns to 1 and `irq_o` is high for exactly one system clock.
- R3: If the next byte is written before the current byte's last bit ends, it follows with no gap: the rising edges keep a spacing of 2*HALF_DIV system clocks across the byte boundary.
- R4: With the internal clock selected and the buffer empty at the end of a byte, the engine parks: `sclk_o`=1, `sdo_o`=1, `busy_o`=1, `shifting_o`=0. This holds for as long as no byte is written.
- R5: In the parked state, a data write releases the wait, and the first falling edge of `sclk_o` comes within 2*HALF_DIV system clocks of the write.
- R6: With the external clock selected and transmission enabled, a falling edge of `ext_sclk_i` that starts a byte slot while the buffer is empty sets `tx_err_o` to 1. `irq_o` pulses on the cycle after the flag is set.
- R7: A control write (`wr_sel_i`=0) with bit 0 (enable) cleared lets the byte in progress finish all 8 bits. After that `busy_o` falls to 0, `sdo_o` stays 1 and no further serial clock edges occur.
- R8: A control write with bit 2 (inhibit) set stops at once. On the next cycle: `busy_o`=0, `shifting_o`=0, `buf_empty_o`=1, `tx_err_o`=0, `sdo_o`=1, `sclk_o`=1. The enable bit is cleared, so a later data write starts nothing.
- R9: A control write with bit 0 set and bit 1 cleared enables the internal clock. `sclk_o` then toggles every HALF_DIV system clocks while it runs and idles high.
- R10: A control write with bits 0 and 1 set enables the external clock. Data bits then advance on synchronized falling edges of `ext_sclk_i`, and `sclk_o` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_sel_i | input | 1 | 0: control word, 1: transmit byte |
| wr_data_i | input | 8 | Write data; control bits: 0 enable, 1 external clock, 2 inhibit |
| ext_sclk_i | input | 1 | External serial clock (asynchronous) |
| sclk_o | output | 1 | Generated serial clock, idle high |
| sdo_o | output | 1 | Serial data out, idle high |
| irq_o | output | 1 | One-cycle interrupt pulse |
| buf_empty_o | output | 1 | Holding buffer is empty |
| busy_o | output | 1 | Transmission enabled and not yet stopped |
| shifting_o | output | 1 | A byte is in the shift register |
| tx_err_o | output | 1 | Sticky external-clock underrun flag |

## Verification
The bench targets the byte boundary. A late write must park the clock high, not emit a stray falling edge. An early write must continue with unchanged rising-edge spacing; a design that paused one tick there would show a stretched period. Graceful stop is issued mid-byte to catch an engine that truncates the byte or keeps clocking. Abort is issued mid-byte and then followed by a data write, which exposes an enable bit that survived the inhibit. In external mode the bench supplies exactly one extra falling edge after a byte, so a missing error flag or a missing interrupt shows at once.

// File: rtl/sst_pkg.sv
// Package: shared state type and control-word bit positions for the
// synchronous serial transmitter. Assumes an 8-bit or wider write bus.
package sst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } sst_state_e;

    localparam int CTL_EN  = 0;
    localparam int CTL_EXT = 1;
    localparam int CTL_INH = 2;
endpackage

// File: rtl/sst_clkgen.sv
// Internal serial clock generator. Divides the system clock so that the
// serial clock toggles every HALF_DIV cycles while run_i is high. A falling
// edge is only taken when allow_fall_i is high, so the clock can be parked
// high. Assumes run_i drops whenever the engine is idle.
module sst_clkgen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic allow_fall_i,
    output logic sclk_o,
    output logic fall_o,
    output logic tick_hi_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          tick;

    assign tick      = run_i && (cnt_q == LAST);
    assign fall_o    = tick && sclk_q && allow_fall_i;
    assign tick_hi_o = tick && sclk_q;
    assign sclk_o    = sclk_q;

    // Divider counter and clock level; parked high when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            if (!sclk_q) begin
                sclk_q <= 1'b1;
            end else if (allow_fall_i) begin
                sclk_q <= 1'b0;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sst_extsync.sv
// External serial clock synchronizer. Passes the asynchronous clock through
// SYNC_STAGES flops (at least 2) and flags each falling edge for one system
// clock. Assumes the external clock's half period spans several system clocks.
module sst_extsync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] stg_q;
    logic                   prev_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[g] <= 1'b1;
                else        stg_q[g] <= ext_i;
            end
        end else begin : g_next
            // Further stages settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[g] <= 1'b1;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    // Remember last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= stg_q[SYNC_STAGES-1];
    end

    assign fall_o = prev_q && !stg_q[SYNC_STAGES-1];
endmodule

// File: rtl/sst_shifter.sv
// Output shift register. Loads a byte and presents its top bit, shifts one
// bit per shift_i, and drives the line high on park_i or clr_i. last_o is
// high while the final bit of the byte is on the line.
module sst_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              shift_i,
    input  logic              park_i,
    output logic              sdo_o,
    output logic              last_o
);
    localparam int LW = (DATA_W > 2) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0] sh_q;
    logic [LW-1:0]     left_q;
    logic              sdo_q;

    // Shift register, remaining-bit count and data line.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sh_q   <= '0;
            left_q <= '0;
            sdo_q  <= 1'b1;
        end else if (load_i) begin
            sh_q   <= data_i << 1;
            left_q <= LW'(DATA_W - 1);
            sdo_q  <= data_i[DATA_W-1];
        end else if (shift_i) begin
            sh_q   <= sh_q << 1;
            left_q <= left_q - 1'b1;
            sdo_q  <= sh_q[DATA_W-1];
        end else if (park_i) begin
            sdo_q  <= 1'b1;
        end
    end

    assign sdo_o  = sdo_q;
    assign last_o = (left_q == '0);
endmodule

// File: rtl/sync_ser_tx.sv
// Synchronous serial byte transmitter, top level. Holds one byte in a
// buffer, sends bytes MSB first on an internal divided clock or a
// synchronized external clock, parks the internal clock when the buffer is
// dry, flags an underrun in external mode, and supports graceful stop and
// immediate abort. Assumes the clock-mode bit is not changed mid-transfer.
module sync_ser_tx
    import sst_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              ext_sclk_i,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              irq_o,
    output logic              buf_empty_o,
    output logic              busy_o,
    output logic              shifting_o,
    output logic              tx_err_o
);
    sst_state_e        state_q, state_d;
    logic              en_q, ext_q;
    logic [DATA_W-1:0] buf_q;
    logic              full_q, err_q, err_pend_q, irq_q;

    logic wr_ctl, wr_dat, inhibit;
    logic int_sclk, int_fall, tick_hi, ext_fall;
    logic allow_fall, run_int, last;
    logic step_fall, frame_end, wait_fall;
    logic load, shift, park, err_evt;

    assign wr_ctl  = wr_en_i && !wr_sel_i;
    assign wr_dat  = wr_en_i && wr_sel_i;
    assign inhibit = wr_ctl && wr_data_i[CTL_INH];

    assign allow_fall = ((state_q == ST_SHIFT) && !last) || (en_q && full_q);
    assign run_int    = (state_q != ST_IDLE) && !ext_q && !inhibit;

    sst_clkgen #(.HALF_DIV(HALF_DIV)) i_clkgen (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_int),
        .allow_fall_i (allow_fall),
        .sclk_o       (int_sclk),
        .fall_o       (int_fall),
        .tick_hi_o    (tick_hi)
    );

    sst_extsync #(.SYNC_STAGES(SYNC_STAGES)) i_extsync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_i  (ext_sclk_i),
        .fall_o (ext_fall)
    );

    // Event decode: which falling edge acts and what it does.
    assign step_fall = ext_q ? ext_fall : int_fall;
    assign frame_end = (state_q == ST_SHIFT) && last && (ext_q ? ext_fall : tick_hi);
    assign wait_fall = (state_q == ST_WAIT) && en_q && step_fall;
    assign load      = !inhibit && en_q && full_q && (frame_end || wait_fall);
    assign shift     = !inhibit && (state_q == ST_SHIFT) && !last && step_fall;
    assign park      = !inhibit && frame_end && !load;
    assign err_evt   = !inhibit && ext_q && en_q && !full_q && ext_fall &&
                       ((state_q == ST_WAIT) || ((state_q == ST_SHIFT) && last));

    sst_shifter #(.DATA_W(DATA_W)) i_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (inhibit),
        .load_i  (load),
        .data_i  (buf_q),
        .shift_i (shift),
        .park_i  (park),
        .sdo_o   (sdo_o),
        .last_o  (last)
    );

    // Next-state logic of the transfer sequencer.
    always_comb begin
        state_d = state_q;
        if (inhibit) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (en_q) state_d = ST_WAIT;
                ST_WAIT:  begin
                    if (!en_q)     state_d = ST_IDLE;
                    else if (load) state_d = ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (frame_end && !load) state_d = en_q ? ST_WAIT : ST_IDLE;
                end
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Control bits: enable and clock-mode select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ext_q <= 1'b0;
        end else if (wr_ctl) begin
            en_q  <= wr_data_i[CTL_EN] && !wr_data_i[CTL_INH];
            ext_q <= wr_data_i[CTL_EXT];
        end
    end

    // Holding buffer and its occupancy; a write wins over a same-cycle load.
    always_ff @(posedge clk) begin
        if (!rst_n || inhibit) begin
            buf_q  <= '0;
            full_q <= 1'b0;
        end else if (wr_dat) begin
            buf_q  <= wr_data_i;
            full_q <= 1'b1;
        end else if (load) begin
            full_q <= 1'b0;
        end
    end

    // Sticky underrun flag and its delayed interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n || inhibit) begin
            err_q      <= 1'b0;
            err_pend_q <= 1'b0;
        end else begin
            err_pend_q <= err_evt;
            if (err_evt) err_q <= 1'b1;
        end
    end

    // Interrupt pulse: byte taken from buffer, or one cycle after underrun.
    always_ff @(posedge clk) begin
        if (!rst_n || inhibit) irq_q <= 1'b0;
        else                   irq_q <= load || err_pend_q;
    end

    assign sclk_o      = (ext_q || (state_q == ST_IDLE)) ? 1'b1 : int_sclk;
    assign irq_o       = irq_q;
    assign buf_empty_o = !full_q;
    assign busy_o      = (state_q != ST_IDLE);
    assign shifting_o  = (state_q == ST_SHIFT);
    assign tx_err_o    = err_q;
endmodule

// File: rtl/sst_checker.sv
// Assertion checker for sync_ser_tx, attached by bind. Observes ports only.
module sst_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic              wr_sel_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              sclk_o,
    input logic              sdo_o,
    input logic              irq_o,
    input logic              buf_empty_o,
    input logic              busy_o,
    input logic              shifting_o,
    input logic              tx_err_o
);
    a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i) |=> !buf_empty_o);

    a_r2_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    a_r2_load_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shifting_o) |-> irq_o);

    a_r6_err_then_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_err_o) |=> irq_o);

    a_r4_rest_high: assert property (@(posedge clk) disable iff (!rst_n)
        !shifting_o |-> (sdo_o && sclk_o));

    a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_sel_i && wr_data_i[2]) |=>
        (!busy_o && !shifting_o && buf_empty_o && !tx_err_o && sdo_o && sclk_o));
endmodule

bind sync_ser_tx sst_checker #(.DATA_W(DATA_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .sclk_o      (sclk_o),
    .sdo_o       (sdo_o),
    .irq_o       (irq_o),
    .buf_empty_o (buf_empty_o),
    .busy_o      (busy_o),
    .shifting_o  (shifting_o),
    .tx_err_o    (tx_err_o)
);

// File: tb/test_sync_ser_tx.sv
module test_sync_ser_tx;
    localparam int HALF = 4;
    localparam int PER  = 2 * HALF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ext_sclk = 1'b1;
    logic       sclk, sdo, irq, buf_empty, busy, shifting, tx_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sync_ser_tx #(.DATA_W(8), .HALF_DIV(HALF), .SYNC_STAGES(2)) i_sync_ser_tx (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .ext_sclk_i(ext_sclk), .sclk_o(sclk), .sdo_o(sdo),
        .irq_o(irq), .buf_empty_o(buf_empty), .busy_o(busy),
        .shifting_o(shifting), .tx_err_o(tx_err)
    );

    // Monitor: capture sdo at each rising sclk edge, count irq cycles.
    logic cap_bit [0:1023];
    int   cap_t   [0:1023];
    int   ncap = 0;
    int   cyc = 0;
    int   n_irq = 0;
    logic pr_sclk = 1'b1;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && !pr_sclk && sclk && ncap < 1024) begin
            cap_bit[ncap] = sdo;
            cap_t[ncap]   = cyc;
            ncap = ncap + 1;
        end
        if (rst_n && irq) n_irq = n_irq + 1;
        pr_sclk = sclk;
    end

    function automatic logic [7:0] got_byte(input int start);
        logic [7:0] b = 8'h00;
        for (int k = 0; k < 8; k++) b = {b[6:0], cap_bit[start + k]};
        return b;
    endfunction

    function automatic logic [7:0] ctl_word(input bit en, input bit ext, input bit inh);
        return {5'b0, inh, ext, en};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 400 && !buf_empty; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    endtask

    task automatic wait_caps(input int n);
        for (int i = 0; i < 400 && ncap < n; i++) @(negedge clk);
    endtask

    task automatic ext_edge(input logic lvl);
        @(negedge clk);
        ext_sclk = lvl;
        repeat (6) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        int t0;
        int n_rand;
        int irq0;
        logic [7:0] exp_b [0:15];
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(buf_empty == 1'b1, "R2 reset buf_empty", buf_empty, 1);
        chk(!busy && !shifting && !tx_err && !irq, "R8 reset flags", {busy, shifting, tx_err, irq}, 0);
        chk(sdo && sclk, "R9 reset idle high", {sdo, sclk}, 3);

        // R3/R9: back-to-back bytes with unchanged clock spacing
        base = ncap;
        wr(1'b0, ctl_word(1, 0, 0));
        wr(1'b1, 8'hA5);
        chk(buf_empty == 1'b0, "R2 write clears empty", buf_empty, 0);
        wait_empty();
        irq0 = n_irq;
        wr(1'b1, 8'h3C);
        wait_empty();
        chk(n_irq == irq0 + 1, "R2 irq per load", n_irq - irq0, 1);
        wr(1'b0, ctl_word(0, 0, 0));
        wait_idle();
        chk(got_byte(base) == 8'hA5, "R1 first byte MSB first", got_byte(base), 8'hA5);
        chk(got_byte(base + 8) == 8'h3C, "R3 second byte", got_byte(base + 8), 8'h3C);
        chk(cap_t[base + 8] - cap_t[base + 7] == PER, "R3 no gap at boundary",
            cap_t[base + 8] - cap_t[base + 7], PER);
        chk(cap_t[base + 1] - cap_t[base] == PER, "R9 clock period",
            cap_t[base + 1] - cap_t[base], PER);
        chk(ncap - base == 16, "R7 bit count after stop", ncap - base, 16);

        // R4/R5: park on dry buffer, then release by a write
        base = ncap;
        wr(1'b0, ctl_word(1, 0, 0));
        wr(1'b1, 8'h81);
        wait_caps(base + 8);
        repeat (20 * HALF) @(negedge clk);
        chk(sclk && sdo && busy && !shifting, "R4 parked", {sclk, sdo, busy, shifting}, 4'b1110);
        chk(ncap == base + 8, "R4 no extra edges", ncap - base, 8);
        wr(1'b1, 8'h5E);
        t0 = 1;
        for (int i = 0; i < 100 && sclk; i++) begin
            @(negedge clk);
            t0++;
        end
        chk(t0 <= PER, "R5 release latency", t0, PER);
        wait_empty();
        wr(1'b0, ctl_word(0, 0, 0));
        wait_idle();
        chk(got_byte(base) == 8'h81 && got_byte(base + 8) == 8'h5E, "R1 bytes around park",
            {got_byte(base), got_byte(base + 8)}, 16'h815E);

        // R7: graceful stop mid-byte
        base = ncap;
        wr(1'b0, ctl_word(1, 0, 0));
        wr(1'b1, 8'hC6);
        wait_caps(base + 3);
        wr(1'b0, ctl_word(0, 0, 0));
        wait_idle();
        repeat (4 * PER) @(negedge clk);
        chk(got_byte(base) == 8'hC6, "R7 byte completes", got_byte(base), 8'hC6);
        chk(ncap - base == 8 && !busy && sdo && sclk, "R7 stopped high",
            ncap - base, 8);

        // R8: abort mid-byte, then a write must not restart
        base = ncap;
        wr(1'b0, ctl_word(1, 0, 0));
        wr(1'b1, 8'h77);
        wait_caps(base + 3);
        wr(1'b0, ctl_word(1, 0, 1));
        chk(!busy && !shifting && buf_empty && !tx_err && sdo && sclk, "R8 abort state",
            {busy, shifting, buf_empty, tx_err, sdo, sclk}, 6'b001011);
        t0 = ncap;
        wr(1'b1, 8'h12);
        repeat (6 * PER) @(negedge clk);
        chk(!busy && ncap == t0 && sclk, "R8 enable cleared", ncap - t0, 0);
        wr(1'b0, ctl_word(0, 0, 1));

        // R10/R6: external clock, one byte, then an underrun slot
        wr(1'b0, ctl_word(1, 1, 0));
        wr(1'b1, 8'hB4);
        begin
            logic [7:0] eb = 8'h00;
            bit sclk_hi = 1'b1;
            for (int k = 0; k < 8; k++) begin
                ext_edge(1'b0);
                eb = {eb[6:0], sdo};
                sclk_hi = sclk_hi && sclk;
                ext_edge(1'b1);
            end
            chk(eb == 8'hB4, "R10 external byte", eb, 8'hB4);
            chk(sclk_hi, "R10 sclk held high", sclk_hi, 1);
        end
        chk(tx_err == 1'b0, "R6 no error yet", tx_err, 0);
        irq0 = n_irq;
        ext_edge(1'b0);
        chk(tx_err == 1'b1 && busy, "R6 underrun flag", tx_err, 1);
        chk(n_irq == irq0 + 1, "R6 underrun irq", n_irq - irq0, 1);
        ext_edge(1'b1);
        wr(1'b0, ctl_word(0, 0, 1));
        chk(tx_err == 1'b0, "R8 abort clears error", tx_err, 0);

        // Random: bytes at random times, internal clock
        base = ncap;
        irq0 = n_irq;
        n_rand = 10;
        wr(1'b0, ctl_word(1, 0, 0));
        for (int i = 0; i < n_rand; i++) begin
            repeat ($urandom_range(0, 90)) @(negedge clk);
            wait_empty();
            exp_b[i] = 8'($urandom_range(0, 255));
            wr(1'b1, exp_b[i]);
        end
        wait_empty();
        wr(1'b0, ctl_word(0, 0, 0));
        wait_idle();
        chk(ncap - base == 8 * n_rand, "R1 random bit count", ncap - base, 8 * n_rand);
        chk(n_irq - irq0 == n_rand, "R2 random irq count", n_irq - irq0, n_rand);
        for (int i = 0; i < n_rand; i++)
            chk(got_byte(base + 8 * i) == exp_b[i], "R1 random byte",
                got_byte(base + 8 * i), exp_b[i]);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule